// File: doc/BRIEF.md
# Timer Time-Base with Shadowed Divider and Period

This block is the counting core of a general-purpose timer. It divides an incoming count tick by a programmable ratio. The result steps a 16-bit counter, which runs upward, downward or up-then-down between zero and a programmable period. Each time the counter reaches a turning point it raises an overflow event. The event sets a sticky flag and produces a one-cycle pulse.

Software drives a small write port. The divider value is always held in a shadow register. The period can be shadowed or used directly, under software control. A shadowed value reaches the running logic only at an overflow event or when software issues an update-generate command. A ratio can therefore be changed mid-period without a short or long count. The enable bit passes through one synchronising register before the logic starts counting.

Top module: `tbase_timer`

## Requirements
- R1: While running, the counter takes one step for every (D+1) clocks in which `tick_i` is high, where D is the active divider.
- R2: A write to the divider register (address 1) has no effect on the step ratio until the next overflow event or update-generate command loads it into the active divider.
- R3: With the period-buffer bit (CTRL address 0, bit 1) clear, a period write (address 2) becomes the active period from the next clock. With the bit set, the written period becomes active only at an overflow event or update-generate.
- R4: Setting the enable bit (CTRL bit 0) starts counting one clock late. A tick in the first clock after the write's edge is ignored. Ticks from the second clock onward are counted.
- R5: In up mode (CTRL bits 4:3 = 0, or the spare code 3), the counter steps 0, 1, … P. The step after it has reached P or above returns it to 0 and is an overflow event.
- R6: In down mode (CTRL bits 4:3 = 1), the counter steps down by one. A step taken at 0 loads P and is an overflow event.
- R7: In up/down mode (CTRL bits 4:3 = 2), the counter climbs to P and then descends to 0. The step leaving P and the step leaving 0 are both overflow events.
- R8: An overflow event sets `ovf_flag_o` and pulses `ovf_pulse_o` for the clock after the step. The flag stays set until a write to CMD (address 3) with bit 0 set clears it. An event in the same clock as the clear wins. The flag resets to 0.
- R9: With the overflow-event enable (CTRL bit 2) clear, the counter still wraps, but the flag, the pulse and the shadow loads are suppressed.
- R10: A CMD write with bit 1 set loads both shadows, sets the counter and prescaler to 0 and the up/down direction to rising, and raises no event.
- R11: With the enable bit clear, the counter and prescaler keep their values.
- R12: With an active period of 0, a counter at 0 stays at 0, and each of its steps is an overflow event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count tick, qualifies each prescaler advance |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 control, 1 divider, 2 period, 3 command |
| wr_data_i | input | 16 | Register write data |
| cnt_o | output | 16 | Current counter value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_pulse_o | output | 1 | One-clock pulse after each overflow event |

## Verification
Directed runs use a constant tick to pin exact counts. These runs separate a correct step ratio from an off-by-one divider, a premature divider load from a deferred one, and a one-clock enable delay from none. Random phases then fix the counting mode and vary tick density, divider, period, buffering and commands. The up, down and up/down sequences, including their turning-point events, are thereby compared against a reference model, step by step. Later phases turn event suppression off and on and mix update-generate and flag-clear writes at random times. These phases show whether shadow loads follow only genuine events, and whether a simultaneous set and clear of the flag resolves toward set.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_CENTER = 2'd2,
    CM_UP_ALT = 2'd3
  } cmode_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] RA_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_PRD  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_CMD  = 3'd3;

  // control field positions
  localparam int CTL_RUN  = 0;
  localparam int CTL_BUF  = 1;
  localparam int CTL_OEN  = 2;
  localparam int CTL_MODE = 3;

  // command field positions
  localparam int CMD_CLR = 0;
  localparam int CMD_UG  = 1;

endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              load_evt,
  output logic              run_o,
  output logic              ovf_en_o,
  output cmode_e            mode_o,
  output logic [W-1:0]      div_act_o,
  output logic [W-1:0]      prd_act_o,
  output logic              ug_o,
  output logic              clr_o
);

  logic         en_q, run_q, buf_q, oen_q;
  cmode_e       mode_q;
  logic [W-1:0] div_q, prd_q, div_sh_q, prd_sh_q;

  logic sel_ctrl, sel_div, sel_prd, sel_cmd, shadow_ld;

  assign sel_ctrl  = wr_en && (wr_addr == RA_CTRL);
  assign sel_div   = wr_en && (wr_addr == RA_DIV);
  assign sel_prd   = wr_en && (wr_addr == RA_PRD);
  assign sel_cmd   = wr_en && (wr_addr == RA_CMD);
  assign ug_o      = sel_cmd && wr_data[CMD_UG];
  assign clr_o     = sel_cmd && wr_data[CMD_CLR];
  assign shadow_ld = ug_o || load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      buf_q  <= 1'b0;
      oen_q  <= 1'b0;
      mode_q <= CM_UP;
    end else if (sel_ctrl) begin
      en_q   <= wr_data[CTL_RUN];
      buf_q  <= wr_data[CTL_BUF];
      oen_q  <= wr_data[CTL_OEN];
      mode_q <= cmode_e'(wr_data[CTL_MODE+1:CTL_MODE]);
    end
  end

  // one synchronising stage between the enable bit and the run signal
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      prd_q <= '0;
    end else begin
      if (sel_div) div_q <= wr_data;
      if (sel_prd) prd_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sh_q <= '0;
      prd_sh_q <= '0;
    end else begin
      if (shadow_ld)           div_sh_q <= div_q;
      if (shadow_ld || !buf_q) prd_sh_q <= prd_q;
    end
  end

  assign run_o     = run_q;
  assign ovf_en_o  = oen_q;
  assign mode_o    = mode_q;
  assign div_act_o = div_sh_q;
  assign prd_act_o = buf_q ? prd_sh_q : prd_q;

  // R2: the active divider moves only on a load
  p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_ld |=> $stable(div_sh_q));

  // R3: a buffered period shadow moves only on a load
  p_prd_buf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_q && !shadow_ld) |=> $stable(prd_sh_q));

  // R4: run rises exactly two edges after the enabling write
  p_run_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ctrl && wr_data[CTL_RUN] && !en_q && !run_q) |=> (!run_q ##1 run_q));

endmodule

// File: rtl/tbase_presc.sv
module tbase_presc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         ug,
  input  logic [W-1:0] div_act,
  output logic         cnt_ce
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] pcnt_q;
  logic         adv;

  assign adv    = run && tick;
  assign cnt_ce = adv && (pcnt_q == div_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (ug)      pcnt_q <= '0;
    else if (adv)     pcnt_q <= cnt_ce ? '0 : pcnt_q + ONE;
  end

  // R1: the prescaler never runs past the active divider
  p_pcnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= div_act);

  // R1: a counter step restarts the prescaler
  p_ce_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ce |=> (pcnt_q == '0));

  // R11: a stopped prescaler keeps its value
  p_presc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug) |=> $stable(pcnt_q));

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cnt_ce,
  input  logic         ug,
  input  logic         clr,
  input  logic         ovf_en,
  input  cmode_e       mode,
  input  logic [W-1:0] prd,
  output logic [W-1:0] cnt_o,
  output logic         ovf_evt_o,
  output logic         flag_o,
  output logic         pulse_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, nxt_cnt;
  logic         dn_q, nxt_dn, wrap_hit;
  logic         flag_q, pulse_q, evt;

  // next value for one counter step, per counting mode
  always_comb begin
    nxt_cnt  = cnt_q;
    nxt_dn   = dn_q;
    wrap_hit = 1'b0;
    unique case (mode)
      CM_DOWN: begin
        if (cnt_q == '0) begin
          nxt_cnt  = prd;
          wrap_hit = 1'b1;
        end else begin
          nxt_cnt = cnt_q - ONE;
        end
      end
      CM_CENTER: begin
        if (prd == '0) begin
          nxt_cnt  = '0;
          wrap_hit = 1'b1;
        end else if (!dn_q) begin
          if (cnt_q >= prd) begin
            nxt_cnt  = cnt_q - ONE;
            nxt_dn   = 1'b1;
            wrap_hit = 1'b1;
          end else begin
            nxt_cnt = cnt_q + ONE;
          end
        end else begin
          if (cnt_q == '0) begin
            nxt_cnt  = ONE;
            nxt_dn   = 1'b0;
            wrap_hit = 1'b1;
          end else begin
            nxt_cnt = cnt_q - ONE;
          end
        end
      end
      default: begin
        if (cnt_q >= prd) begin
          nxt_cnt  = '0;
          wrap_hit = 1'b1;
        end else begin
          nxt_cnt = cnt_q + ONE;
        end
      end
    endcase
  end

  assign evt = cnt_ce && wrap_hit && ovf_en && !ug;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (ug) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q <= nxt_cnt;
      dn_q  <= nxt_dn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= evt;
      if (evt)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign ovf_evt_o = evt;
  assign flag_o    = flag_q;
  assign pulse_o   = pulse_q;

  // R8: an event always leaves the flag and the pulse set
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (flag_q && pulse_q));

  // R9: no pulse while events are disabled
  p_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_en |=> !pulse_q);

  // R10: update-generate leaves the counter at zero
  p_ug_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ug |=> (cnt_q == '0));

  // R11: a stopped timer keeps its count
  p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ug) |=> $stable(cnt_q));

  // R12: a zero period pins the counter at zero
  p_zero_prd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (prd == '0 && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      cnt_o,
  output logic              ovf_flag_o,
  output logic              ovf_pulse_o
);

  logic         run, ovf_en, ug, clr, cnt_ce, ovf_evt;
  cmode_e       mode;
  logic [W-1:0] div_act, prd_act;

  tbase_regs #(.W(W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .load_evt  (ovf_evt),
    .run_o     (run),
    .ovf_en_o  (ovf_en),
    .mode_o    (mode),
    .div_act_o (div_act),
    .prd_act_o (prd_act),
    .ug_o      (ug),
    .clr_o     (clr)
  );

  tbase_presc #(.W(W)) presc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick_i),
    .ug      (ug),
    .div_act (div_act),
    .cnt_ce  (cnt_ce)
  );

  tbase_counter #(.W(W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cnt_ce    (cnt_ce),
    .ug        (ug),
    .clr       (clr),
    .ovf_en    (ovf_en),
    .mode      (mode),
    .prd       (prd_act),
    .cnt_o     (cnt_o),
    .ovf_evt_o (ovf_evt),
    .flag_o    (ovf_flag_o),
    .pulse_o   (ovf_pulse_o)
  );

endmodule

// File: tb/tbase_timer_tb.sv
module tbase_timer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] cnt_o;
  logic        ovf_flag_o, ovf_pulse_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit tick_all = 1'b1;
  string lbl = "R5";

  always #(CLK_PERIOD/2) clk = ~clk;

  tbase_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .cnt_o(cnt_o),
    .ovf_flag_o(ovf_flag_o), .ovf_pulse_o(ovf_pulse_o)
  );

  // ---------------- reference model, built from the requirements
  bit        m_en, m_run, m_buf, m_oen, m_dn, m_flag, m_pulse;
  bit [1:0]  m_mode;
  int        m_div, m_prd, m_div_sh, m_prd_sh, m_pc, m_cnt;
  int        t_p;
  bit        t_ug, t_clr, t_ce, t_evt;
  logic [17:0] t_nx;

  // returns {wrap, falling, count} for one counter step
  function automatic logic [17:0] ref_next(bit [1:0] md, int c, bit dn, int p);
    if (md == 2'd1) begin
      if (c == 0) return {1'b1, dn, 16'(p)};
      return {1'b0, dn, 16'(c - 1)};
    end
    if (md == 2'd2) begin
      if (p == 0) return {1'b1, dn, 16'd0};
      if (dn)     return (c == 0) ? {1'b1, 1'b0, 16'd1} : {1'b0, 1'b1, 16'(c - 1)};
      if (c < p)  return {1'b0, 1'b0, 16'(c + 1)};
      return {1'b1, 1'b1, 16'(c - 1)};
    end
    if (c < p) return {1'b0, dn, 16'(c + 1)};
    return {1'b1, dn, 16'd0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_run = 0; m_buf = 0; m_oen = 0; m_dn = 0; m_flag = 0; m_pulse = 0;
      m_mode = 0; m_div = 0; m_prd = 0; m_div_sh = 0; m_prd_sh = 0; m_pc = 0; m_cnt = 0;
    end else begin
      t_p   = m_buf ? m_prd_sh : m_prd;
      t_ug  = wr_en_i && wr_addr_i == 3 && wr_data_i[1];
      t_clr = wr_en_i && wr_addr_i == 3 && wr_data_i[0];
      t_ce  = m_run && tick_i && (m_pc == m_div_sh);
      t_nx  = ref_next(m_mode, m_cnt, m_dn, t_p);
      t_evt = t_ce && t_nx[17] && m_oen && !t_ug;
      m_pulse = t_evt;
      if (t_evt) m_flag = 1; else if (t_clr) m_flag = 0;
      if (t_ug) begin
        m_cnt = 0; m_dn = 0; m_pc = 0;
      end else if (m_run && tick_i) begin
        m_pc = t_ce ? 0 : m_pc + 1;
        if (t_ce) begin m_cnt = int'(t_nx[15:0]); m_dn = t_nx[16]; end
      end
      if (t_ug || t_evt) m_div_sh = m_div;
      if (t_ug || t_evt || !m_buf) m_prd_sh = m_prd;
      m_run = m_en;
      if (wr_en_i && wr_addr_i == 0) begin
        m_en = wr_data_i[0]; m_buf = wr_data_i[1]; m_oen = wr_data_i[2];
        m_mode = wr_data_i[4:3];
      end
      if (wr_en_i && wr_addr_i == 1) m_div = int'(wr_data_i);
      if (wr_en_i && wr_addr_i == 2) m_prd = int'(wr_data_i);
    end
  end

  // ---------------- checking
  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(lbl, "model cnt", int'(cnt_o), m_cnt);
      check("R8", "model flag", int'(ovf_flag_o), int'(m_flag));
      check("R8", "model pulse", int'(ovf_pulse_o), int'(m_pulse));
    end
  end

  task automatic drive_tick();
    tick_i = tick_all ? 1'b1 : ($urandom_range(0, 2) != 0);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      drive_tick();
      @(negedge clk);
    end
  endtask

  task automatic wr(bit [2:0] a, bit [15:0] d);
    drive_tick();
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  function automatic bit [15:0] ctl(bit run, bit bf, bit oen, bit [1:0] md);
    return {11'd0, md, oen, bf, run};
  endfunction

  task automatic phase(string l, int iters, int md, bit bf, bit oen, bit allow_ug);
    lbl = l;
    for (int i = 0; i < iters; i++) begin
      int r = $urandom_range(0, 11);
      if (r == 0)      wr(3'd1, 16'($urandom_range(0, 3)));
      else if (r == 1) wr(3'd2, 16'($urandom_range(0, 15)));
      else if (r == 2) wr(3'd3, {14'd0, allow_ug && ($urandom_range(0, 1) == 1), 1'b1});
      else if (r == 3) wr(3'd0, ctl($urandom_range(0, 7) != 0, bf, oen,
                                    (md < 0) ? 2'($urandom_range(0, 3)) : 2'(md)));
      else             cyc($urandom_range(1, 6));
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "reset flag", int'(ovf_flag_o), 0);
    check("R8", "reset pulse", int'(ovf_pulse_o), 0);
    check("R11", "reset cnt", int'(cnt_o), 0);
    cmp_on = 1'b1;

    // R4: enable delay with a constant tick
    tick_all = 1'b1;
    wr(3'd2, 16'd100);
    wr(3'd0, ctl(1, 0, 1, 2'd0));
    check("R4", "cnt after enable write", int'(cnt_o), 0);
    cyc(1);
    check("R4", "cnt one clock later", int'(cnt_o), 0);
    cyc(1);
    check("R4", "cnt two clocks later", int'(cnt_o), 1);

    // R1: divider 2 after update-generate gives one step per three ticks
    wr(3'd1, 16'd2);
    wr(3'd3, 16'h0002);
    check("R10", "cnt after update-generate", int'(cnt_o), 0);
    cyc(30);
    check("R1", "cnt after 30 ticks at ratio 3", int'(cnt_o), 10);

    // R2: new divider waits for an overflow
    wr(3'd1, 16'd0);
    cyc(8);
    check("R2", "cnt keeps old ratio", int'(cnt_o), 13);

    // R12: zero period
    wr(3'd2, 16'd0);
    wr(3'd3, 16'h0002);
    cyc(5);
    check("R12", "cnt with zero period", int'(cnt_o), 0);
    check("R12", "flag with zero period", int'(ovf_flag_o), 1);

    // R8: clear with the timer stopped
    wr(3'd0, ctl(0, 0, 1, 2'd0));
    cyc(2);
    wr(3'd3, 16'h0001);
    check("R8", "flag after clear", int'(ovf_flag_o), 0);

    // R11: stopping holds the count
    wr(3'd2, 16'd50);
    wr(3'd0, ctl(1, 0, 1, 2'd0));
    cyc(20);
    wr(3'd0, ctl(0, 0, 1, 2'd0));
    cyc(2);
    held = int'(cnt_o);
    cyc(10);
    check("R11", "cnt held while stopped", int'(cnt_o), held);
    check("R11", "held cnt non-zero", int'(held != 0), 1);

    // model-compared random phases, one behaviour each
    tick_all = 1'b0;
    wr(3'd1, 16'd1);
    wr(3'd2, 16'd9);
    wr(3'd3, 16'h0003);
    phase("R5", 400, 0, 0, 1, 0);
    phase("R6", 400, 1, 0, 1, 0);
    phase("R7", 400, 2, 0, 1, 0);
    phase("R3", 500, -1, 1, 1, 0);
    phase("R9", 400, -1, 1, 0, 0);
    phase("R10", 500, -1, 1, 1, 1);
    tick_all = 1'b1;
    phase("R1", 400, -1, 0, 1, 1);
    phase("R2", 400, -1, 1, 1, 1);
    cyc(4);
    finish_run();
  end

endmodule